// File: doc/BRIEF.md
# Burst Address Sequencer with Dual Strobes

This block produces the word address for each beat of a four-word burst in a synchronous pipelined burst memory. A burst begins when either of two active-low address strobes is seen on a rising clock edge: one driven by a processor and one driven by a memory controller. The chip enables gate each strobe by its own rule. A valid start captures the external address bus and the burst-order select level. After that, each clock with the advance input low moves to the next beat. With advance high, the current beat is held and wait states are inserted.

Only the low address bits take part in the burst. The burst length is a power of two and defaults to four, so two bits move. Those bits follow a linear order (add the beat number modulo the burst length) or an interleaved order (XOR the beat number into the start bits). The bits above them stay frozen for the whole burst. When advance is applied after the last beat, the sequence wraps back to the start address, so the burst never leaves its aligned block. A deselect cycle drops the beat-valid flag and does not disturb the held address.

Top module: `burst_addr_seq`

## Requirements
- R1: While rst_n is low and on the first cycle after it, beat_vld is 0 and word_addr is 0.
- R2: A processor strobe (cpu_strb_n = 0) sampled with all enables active (ce_n = 0, ce2_n = 0, ce_hi = 1) loads ext_addr, and has priority over the controller strobe and over advance. After that edge, word_addr equals ext_addr and beat_vld is 1.
- R3: A controller strobe (ctl_strb_n = 0) without a processor strobe, sampled with all enables active, loads ext_addr. This holds also in the middle of a burst, which abandons the old burst.
- R4: A deselect drops beat_vld to 0 after the edge and leaves word_addr unchanged. A deselect is either of these: a controller strobe with any enable inactive, or a processor strobe with ce_n = 0 and ce2_n or ce_hi inactive.
- R5: A processor strobe sampled with ce_n = 1 is ignored, and the cycle behaves as if cpu_strb_n were 1.
- R6: With order_sel = 0 captured at the start, beat n has low bits equal to (start_low + n) mod 4.
- R7: With order_sel = 1 captured at the start, beat n has low bits equal to start_low XOR n.
- R8: With beat_vld = 1 and no strobe, adv_n = 0 moves to the next beat on that edge, and adv_n = 1 holds word_addr and beat_vld.
- R9: An advance from the fourth beat returns word_addr to the start address.
- R10: The bits of word_addr above the two low bits stay equal to the captured start address for the whole burst.
- R11: Advance with beat_vld = 0 and no strobe changes neither output.
- R12: A change of order_sel during a burst does not alter the order of that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_addr | input | ADDR_W | External start address bus |
| ctl_strb_n | input | 1 | Controller address strobe, active low |
| cpu_strb_n | input | 1 | Processor address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce_n | input | 1 | Chip enable, active low; gates both strobes |
| ce_hi | input | 1 | Chip enable, active high |
| ce2_n | input | 1 | Second chip enable, active low |
| order_sel | input | 1 | Burst order: 1 interleaved, 0 linear |
| word_addr | output | ADDR_W | Address of the current beat |
| beat_vld | output | 1 | Current beat is part of a live burst |

## Verification
The bench goes after these cases. A wrap from the fourth beat: a design that carried out of the low bits would step into the next aligned block. A processor strobe with ce_n high: a design that gated it like the controller strobe would deselect instead of carrying on the burst. A controller reload in the middle of a burst, which must restart at beat zero rather than continue the old count. A toggle of order_sel in the middle of a burst, and advance pulses while deselected, which would corrupt the sequence if the order were read live or the counter ran free.

// File: rtl/bas_pkg.sv
package bas_pkg;
   typedef enum logic [1:0] {
      CMD_HOLD  = 2'd0,
      CMD_LOAD  = 2'd1,
      CMD_DESEL = 2'd2,
      CMD_STEP  = 2'd3
   } bas_cmd_e;

   localparam int unsigned ORD_PIN        = 0;
   localparam int unsigned ORD_LINEAR     = 1;
   localparam int unsigned ORD_INTERLEAVE = 2;
endpackage

// File: rtl/bas_cmd_decode.sv
module bas_cmd_decode
   import bas_pkg::*;
(
   input  logic     ctl_strb_n,
   input  logic     cpu_strb_n,
   input  logic     adv_n,
   input  logic     ce_n,
   input  logic     ce_hi,
   input  logic     ce2_n,
   input  logic     vld_q,
   output bas_cmd_e cmd
);
   logic all_en;
   logic cpu_seen;

   assign all_en   = ~ce_n & ce_hi & ~ce2_n;
   // the processor strobe only counts when the primary enable is active
   assign cpu_seen = ~cpu_strb_n & ~ce_n;

   always_comb begin
      cmd = CMD_HOLD;
      if (cpu_seen) begin
         cmd = all_en ? CMD_LOAD : CMD_DESEL;
      end else if (!ctl_strb_n) begin
         cmd = all_en ? CMD_LOAD : CMD_DESEL;
      end else if (!adv_n && vld_q) begin
         cmd = CMD_STEP;
      end
   end
endmodule

// File: rtl/bas_beat_ctr.sv
module bas_beat_ctr
   import bas_pkg::*;
#(
   parameter int unsigned BURST_LEN = 4,
   localparam int unsigned BEAT_W   = $clog2(BURST_LEN)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  bas_cmd_e          cmd,
   output logic [BEAT_W-1:0] beat_q,
   output logic              vld_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         beat_q <= '0;
         vld_q  <= 1'b0;
      end else begin
         unique case (cmd)
            CMD_LOAD: begin
               beat_q <= '0;
               vld_q  <= 1'b1;
            end
            CMD_DESEL: vld_q  <= 1'b0;
            CMD_STEP:  beat_q <= beat_q + 1'b1;
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/bas_order_map.sv
module bas_order_map
   import bas_pkg::*;
#(
   parameter int unsigned BURST_LEN  = 4,
   parameter int unsigned ORDER_MODE = ORD_PIN,
   localparam int unsigned BEAT_W    = $clog2(BURST_LEN)
) (
   input  logic [BEAT_W-1:0] start_low,
   input  logic [BEAT_W-1:0] beat,
   input  logic              ilv_q,
   output logic [BEAT_W-1:0] cur_low
);
   logic [BEAT_W-1:0] lin_low;
   logic [BEAT_W-1:0] ilv_low;

   assign lin_low = start_low + beat;
   assign ilv_low = start_low ^ beat;

   generate
      if (ORDER_MODE == ORD_LINEAR) begin : g_lin
         assign cur_low = lin_low;
      end else if (ORDER_MODE == ORD_INTERLEAVE) begin : g_ilv
         assign cur_low = ilv_low;
      end else begin : g_pin
         assign cur_low = ilv_q ? ilv_low : lin_low;
      end
   endgenerate
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
   import bas_pkg::*;
#(
   parameter int unsigned ADDR_W     = 20,
   parameter int unsigned BURST_LEN  = 4,
   parameter int unsigned ORDER_MODE = ORD_PIN
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] ext_addr,
   input  logic              ctl_strb_n,
   input  logic              cpu_strb_n,
   input  logic              adv_n,
   input  logic              ce_n,
   input  logic              ce_hi,
   input  logic              ce2_n,
   input  logic              order_sel,
   output logic [ADDR_W-1:0] word_addr,
   output logic              beat_vld
);
   localparam int unsigned BEAT_W = $clog2(BURST_LEN);

   generate
      if (BURST_LEN < 2 || (BURST_LEN & (BURST_LEN - 1)) != 0) begin : g_bad_len
         $error("BURST_LEN must be a power of two of at least 2");
      end
      if (ADDR_W <= BEAT_W) begin : g_bad_aw
         $error("ADDR_W must exceed the beat index width");
      end
      if (ORDER_MODE > ORD_INTERLEAVE) begin : g_bad_ord
         $error("ORDER_MODE out of range");
      end
   endgenerate

   bas_cmd_e          cmd;
   logic              vld_q;
   logic [BEAT_W-1:0] beat_q;
   logic [ADDR_W-1:0] start_q;
   logic              ilv_q;
   logic [BEAT_W-1:0] cur_low;

   bas_cmd_decode u_dec (
      .ctl_strb_n (ctl_strb_n),
      .cpu_strb_n (cpu_strb_n),
      .adv_n      (adv_n),
      .ce_n       (ce_n),
      .ce_hi      (ce_hi),
      .ce2_n      (ce2_n),
      .vld_q      (vld_q),
      .cmd        (cmd)
   );

   bas_beat_ctr #(.BURST_LEN(BURST_LEN)) u_ctr (
      .clk    (clk),
      .rst_n  (rst_n),
      .cmd    (cmd),
      .beat_q (beat_q),
      .vld_q  (vld_q)
   );

   // start address and order are captured only when a burst begins
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         start_q <= '0;
         ilv_q   <= 1'b0;
      end else if (cmd == CMD_LOAD) begin
         start_q <= ext_addr;
         ilv_q   <= order_sel;
      end
   end

   bas_order_map #(.BURST_LEN(BURST_LEN), .ORDER_MODE(ORDER_MODE)) u_map (
      .start_low (start_q[BEAT_W-1:0]),
      .beat      (beat_q),
      .ilv_q     (ilv_q),
      .cur_low   (cur_low)
   );

   assign word_addr = {start_q[ADDR_W-1:BEAT_W], cur_low};
   assign beat_vld  = vld_q;
endmodule

// File: rtl/bas_checker.sv
module bas_checker #(
   parameter int unsigned ADDR_W    = 20,
   parameter int unsigned BURST_LEN = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] ext_addr,
   input logic              ctl_strb_n,
   input logic              cpu_strb_n,
   input logic              adv_n,
   input logic              ce_n,
   input logic              ce_hi,
   input logic              ce2_n,
   input logic [ADDR_W-1:0] word_addr,
   input logic              beat_vld
);
   localparam int unsigned BEAT_W = $clog2(BURST_LEN);

   logic all_on;
   logic quiet;
   assign all_on = ~ce_n & ce_hi & ~ce2_n;
   assign quiet  = cpu_strb_n & ctl_strb_n;

   AST_CPU_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (!cpu_strb_n && all_on) |=> (beat_vld && word_addr == $past(ext_addr))); // R2

   AST_CTL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_strb_n && !ctl_strb_n && all_on) |=> (beat_vld && word_addr == $past(ext_addr))); // R3

   AST_DESEL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_strb_n && !ctl_strb_n && !all_on) |=> (!beat_vld && $stable(word_addr))); // R4

   AST_CPU_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (!cpu_strb_n && ce_n && ctl_strb_n && adv_n) |=> ($stable(word_addr) && $stable(beat_vld))); // R5

   AST_HOLD_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_vld && quiet && adv_n) |=> ($stable(word_addr) && beat_vld)); // R8

   AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_vld && quiet && !adv_n) |=>
         (word_addr[ADDR_W-1:BEAT_W] == $past(word_addr[ADDR_W-1:BEAT_W]))); // R10

   AST_IDLE_ADV: assert property (@(posedge clk) disable iff (!rst_n)
      (!beat_vld && quiet) |=> (!beat_vld && $stable(word_addr))); // R11
endmodule

bind burst_addr_seq bas_checker #(.ADDR_W(ADDR_W), .BURST_LEN(BURST_LEN)) u_bas_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ext_addr   (ext_addr),
   .ctl_strb_n (ctl_strb_n),
   .cpu_strb_n (cpu_strb_n),
   .adv_n      (adv_n),
   .ce_n       (ce_n),
   .ce_hi      (ce_hi),
   .ce2_n      (ce2_n),
   .word_addr  (word_addr),
   .beat_vld   (beat_vld)
);

// File: tb/tb_burst_addr_seq.sv
module tb_burst_addr_seq;
   localparam int AW = 20;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] ext_addr = '0;
   logic          ctl_strb_n = 1'b1;
   logic          cpu_strb_n = 1'b1;
   logic          adv_n = 1'b1;
   logic          ce_n = 1'b0;
   logic          ce_hi = 1'b1;
   logic          ce2_n = 1'b0;
   logic          order_sel = 1'b0;
   logic [AW-1:0] word_addr;
   logic          beat_vld;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit done = 0;

   // behavioural reference state
   int m_vld = 0;
   int m_start = 0;
   int m_beat = 0;
   int m_ilv = 0;

   always #10 clk = ~clk;

   burst_addr_seq dut (
      .clk(clk), .rst_n(rst_n), .ext_addr(ext_addr),
      .ctl_strb_n(ctl_strb_n), .cpu_strb_n(cpu_strb_n), .adv_n(adv_n),
      .ce_n(ce_n), .ce_hi(ce_hi), .ce2_n(ce2_n), .order_sel(order_sel),
      .word_addr(word_addr), .beat_vld(beat_vld)
   );

   function automatic int exp_addr();
      int lo;
      lo = m_start % 4;
      if (m_ilv != 0) lo = lo ^ m_beat;
      else            lo = (lo + m_beat) % 4;
      return (m_start / 4) * 4 + lo;
   endfunction

   function automatic void model_step();
      bit en_all;
      en_all = !ce_n && ce_hi && !ce2_n;
      if (!rst_n) begin
         m_vld = 0; m_start = 0; m_beat = 0; m_ilv = 0;
      end else if ((!cpu_strb_n && !ce_n) || !ctl_strb_n) begin
         if (en_all) begin
            m_vld = 1; m_start = int'(ext_addr); m_beat = 0; m_ilv = int'(order_sel);
         end else begin
            m_vld = 0;
         end
      end else if (!adv_n && m_vld != 0) begin
         m_beat = (m_beat + 1) % 4;
      end
   endfunction

   task automatic compare(input string tag);
      checks++;
      if (int'(word_addr) != exp_addr() || int'(beat_vld) != m_vld) begin
         errors++;
         $display("FAIL %s cycle %0d: addr %0h vld %0d, expected addr %0h vld %0d",
                  tag, cyc, word_addr, beat_vld, exp_addr(), m_vld);
      end
   endtask

   // inputs set on the falling edge, model advanced, result checked one falling edge later
   task automatic step(input string tag);
      model_step();
      @(negedge clk);
      cyc++;
      compare(tag);
   endtask

   task automatic idle_in();
      cpu_strb_n = 1; ctl_strb_n = 1; adv_n = 1;
      ce_n = 0; ce_hi = 1; ce2_n = 0;
   endtask

   task automatic advance(input int n, input string tag);
      for (int i = 0; i < n; i++) begin
         idle_in(); adv_n = 0;
         step(tag);
      end
   endtask

   initial begin
      @(negedge clk);
      step("R1");
      step("R1");
      rst_n = 1;
      idle_in();
      step("R1");

      // linear burst from low bits 2, then wrap
      ext_addr = 20'hABC06; order_sel = 0; cpu_strb_n = 0; adv_n = 0; ctl_strb_n = 0;
      step("R2");
      advance(3, "R6");
      advance(1, "R9");
      advance(1, "R10");
      idle_in();
      step("R8");
      step("R8");

      // interleaved burst from low bits 1, order pin toggled mid-burst
      idle_in(); ext_addr = 20'h12345; order_sel = 1; ctl_strb_n = 0;
      step("R3");
      advance(2, "R7");
      order_sel = 0;
      advance(2, "R12");
      advance(1, "R9");

      // controller reload abandons the burst
      idle_in(); ext_addr = 20'h0F00B; ctl_strb_n = 0;
      step("R3");

      // processor strobe with ce_n high is ignored
      idle_in(); cpu_strb_n = 0; ce_n = 1;
      step("R5");
      idle_in(); cpu_strb_n = 0; ce_n = 1; adv_n = 0;
      step("R5");

      // deselect by controller with an enable off, then advance while idle
      idle_in(); ctl_strb_n = 0; ce_hi = 0; ext_addr = 20'h55555;
      step("R4");
      advance(2, "R11");

      // processor strobe with a secondary enable off
      idle_in(); ext_addr = 20'h00003; cpu_strb_n = 0;
      step("R2");
      idle_in(); cpu_strb_n = 0; ce2_n = 1;
      step("R4");

      // pseudo-random traffic with the model compared every cycle
      for (int i = 0; i < 3000; i++) begin
         int r;
         r = int'($urandom % 16);
         ext_addr   = AW'($urandom);
         cpu_strb_n = (r < 2) ? 1'b0 : 1'b1;
         ctl_strb_n = (r == 3 || r == 4) ? 1'b0 : 1'b1;
         adv_n      = ($urandom % 3) == 0;
         ce_n       = ($urandom % 6) == 0;
         ce_hi      = ($urandom % 6) != 0;
         ce2_n      = ($urandom % 6) == 0;
         order_sel  = $urandom % 2;
         step("R8");
      end
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired at cycle %0d", cyc);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule